// File: doc/BRIEF.md
# Exception Entry Stacking Sequencer

This block carries out the hardware half of a processor core's context save when an interrupt is accepted. A take request with an exception number arms it. It then waits for the core to report an instruction boundary, which means the instruction in flight has retired. At that boundary it captures a fixed set of eight register values and the stack pointer. It writes the eight words to stack memory through a word-wide write port with a request/acknowledge handshake. The stack is full-descending, so the pointer is lowered by four bytes before each write.

Once the last word is accepted, the block fetches the handler address from the vector table through a read port with its own request/acknowledge handshake. It then presents four new register values to the core in a single cycle, flagged by a one-cycle done pulse:

- the lowered stack pointer,
- the fixed return marker for the link register,
- the status word with its exception-number field replaced,
- the handler address for the program counter.

The core keeps the registers outside the saved set itself. Software saves those registers if it needs them.

Top module: `exc_entry_seq`

## Requirements
- R1: No stack write is issued before `instr_done_i` has been seen high in a cycle after the take request was accepted.
- R2: Exactly eight words are written per entry, in this order: status, PC, LR, R12, R3, R2, R1, R0. No other register value is written.
- R3: With `S` the stack pointer captured at the boundary, the k-th write (k = 0..7) goes to byte address `S - 4*(k+1)`. Each address is 4 below the previous one, so R0 lands at `S - 32`, the lowest slot, and the status word lands at `S - 4`.
- R4: When `done_o` is high, `sp_o` equals `S - 32`.
- R5: When `done_o` is high, `lr_o` equals 32'hFFFFFFF9.
- R6: When `done_o` is high, `psr_o` equals the captured status word with bits [EXC_W-1:0] replaced by the accepted exception number.
- R7: The vector read is requested only after all eight writes are acknowledged. Its address is `vec_base_i + 4*exception number`. When `done_o` is high, `pc_o` equals the `vec_data_i` value that was acknowledged.
- R8: `done_o` is high for exactly one cycle per entry. In the cycle after it, `busy_o` is low.
- R9: A take request arriving while `busy_o` is high is ignored. It changes neither the exception number used nor the number of writes, and it starts no further sequence.
- R10: A write request holds its address and data stable until `mem_ack_i` is seen.
- R11: Register values are captured at the instruction boundary. Later changes on the register inputs do not alter the stacked words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| take_i | input | 1 | Take-interrupt request, sampled while idle |
| exc_num_i | input | EXC_W | Exception number carried with the request |
| instr_done_i | input | 1 | Current instruction has retired |
| psr_i | input | 32 | Current status word |
| pc_i | input | 32 | Current program counter |
| lr_i | input | 32 | Current link register |
| r12_i | input | 32 | Current R12 |
| r3_i | input | 32 | Current R3 |
| r2_i | input | 32 | Current R2 |
| r1_i | input | 32 | Current R1 |
| r0_i | input | 32 | Current R0 |
| sp_i | input | 32 | Current stack pointer |
| vec_base_i | input | 32 | Vector table base address |
| mem_we_o | output | 1 | Stack write request |
| mem_addr_o | output | 32 | Stack write byte address |
| mem_wdata_o | output | 32 | Stack write data |
| mem_ack_i | input | 1 | Stack write accepted |
| vec_req_o | output | 1 | Vector read request |
| vec_addr_o | output | 32 | Vector entry byte address |
| vec_data_i | input | 32 | Vector entry contents |
| vec_ack_i | input | 1 | Vector read data valid |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: register updates valid |
| sp_o | output | 32 | New stack pointer |
| lr_o | output | 32 | New link register |
| psr_o | output | 32 | New status word |
| pc_o | output | 32 | New program counter (handler address) |

## Verification
The bench sweeps every exception number of a 6-bit configuration. For each entry it varies the boundary delay, the write latency and the vector-read latency. The status word it feeds carries ones in its low bits, so a design that ORs the number in instead of replacing the field produces a wrong `psr_o`. It checks every address and data word against the frame computed arithmetically. A reversed frame order, a missing pre-decrement, or a pointer that moves on without an acknowledge shows up as a mismatch on a specific slot. On some runs it raises a second take mid-sequence, and it corrupts the register inputs after the boundary. A design that re-arms while busy, or that stacks live inputs instead of a snapshot, then shows extra writes, a wrong exception field or altered words.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned FRAME_WORDS = 8;
  localparam logic [WORD_W-1:0] RET_MARKER = 32'hFFFF_FFF9;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_PUSH,
    ST_VEC,
    ST_DONE
  } entry_state_e;
endpackage

// File: rtl/entry_frame_mux.sv
module entry_frame_mux #(
  parameter int unsigned DW = 32,
  parameter int unsigned NW = 8,
  localparam int unsigned IW = $clog2(NW)
) (
  input  logic [NW-1:0][DW-1:0] words_i,
  input  logic [IW-1:0]         sel_i,
  output logic [DW-1:0]         word_o
);
  logic [NW-1:0][DW-1:0] masked;

  // AND-OR select keeps depth flat
  for (genvar g = 0; g < NW; g++) begin : g_slot
    assign masked[g] = (sel_i == IW'(g)) ? words_i[g] : '0;
  end

  always_comb begin
    word_o = '0;
    for (int i = 0; i < NW; i++) word_o = word_o | masked[i];
  end
endmodule

// File: rtl/entry_addr_gen.sv
module entry_addr_gen #(
  parameter int unsigned AW    = 32,
  parameter int unsigned EXC_W = 6
) (
  input  logic [AW-1:0]    sp_cur_i,
  input  logic [AW-1:0]    vec_base_i,
  input  logic [EXC_W-1:0] exc_num_i,
  output logic [AW-1:0]    push_addr_o,
  output logic [AW-1:0]    vec_addr_o
);
  localparam int unsigned PAD_W = AW - EXC_W - 2;

  assign push_addr_o = sp_cur_i - AW'(4);
  assign vec_addr_o  = vec_base_i + {{PAD_W{1'b0}}, exc_num_i, 2'b00};
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_entry_pkg::*;
#(
  parameter int unsigned EXC_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [EXC_W-1:0]  exc_num_i,
  input  logic              instr_done_i,
  input  logic [31:0]       psr_i,
  input  logic [31:0]       pc_i,
  input  logic [31:0]       lr_i,
  input  logic [31:0]       r12_i,
  input  logic [31:0]       r3_i,
  input  logic [31:0]       r2_i,
  input  logic [31:0]       r1_i,
  input  logic [31:0]       r0_i,
  input  logic [31:0]       sp_i,
  input  logic [31:0]       vec_base_i,
  output logic              mem_we_o,
  output logic [31:0]       mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  output logic              vec_req_o,
  output logic [31:0]       vec_addr_o,
  input  logic [31:0]       vec_data_i,
  input  logic              vec_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       sp_o,
  output logic [31:0]       lr_o,
  output logic [31:0]       psr_o,
  output logic [31:0]       pc_o
);
  localparam int unsigned NW = FRAME_WORDS;
  localparam int unsigned IW = $clog2(NW);
  localparam logic [IW-1:0] LAST_IDX = IW'(NW - 1);

  entry_state_e              state_q;
  logic [IW-1:0]             idx_q;
  logic [EXC_W-1:0]          exc_q;
  logic [WORD_W-1:0]         sp_q;
  logic [WORD_W-1:0]         handler_q;
  logic [NW-1:0][WORD_W-1:0] frame_q;
  logic [NW-1:0][WORD_W-1:0] frame_in;
  logic [WORD_W-1:0]         push_addr;

  // index 0 = deepest slot (status), index 7 = top (R0)
  assign frame_in = {r0_i, r1_i, r2_i, r3_i, r12_i, lr_i, pc_i, psr_i};

  entry_addr_gen #(.AW(WORD_W), .EXC_W(EXC_W)) u_addr (
    .sp_cur_i    (sp_q),
    .vec_base_i  (vec_base_i),
    .exc_num_i   (exc_q),
    .push_addr_o (push_addr),
    .vec_addr_o  (vec_addr_o)
  );

  entry_frame_mux #(.DW(WORD_W), .NW(NW)) u_mux (
    .words_i (frame_q),
    .sel_i   (idx_q),
    .word_o  (mem_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      idx_q     <= '0;
      exc_q     <= '0;
      sp_q      <= '0;
      handler_q <= '0;
      frame_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (take_i) begin
          exc_q   <= exc_num_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (instr_done_i) begin
          frame_q <= frame_in;
          sp_q    <= sp_i;
          idx_q   <= '0;
          state_q <= ST_PUSH;
        end
        ST_PUSH: if (mem_ack_i) begin
          sp_q  <= push_addr;
          idx_q <= idx_q + 1'b1;
          if (idx_q == LAST_IDX) state_q <= ST_VEC;
        end
        ST_VEC: if (vec_ack_i) begin
          handler_q <= vec_data_i;
          state_q   <= ST_DONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_we_o   = (state_q == ST_PUSH);
  assign mem_addr_o = push_addr;
  assign vec_req_o  = (state_q == ST_VEC);
  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_DONE);
  assign sp_o       = sp_q;
  assign lr_o       = RET_MARKER;
  assign psr_o      = {frame_q[0][WORD_W-1:EXC_W], exc_q};
  assign pc_o       = handler_q;
endmodule

module exc_entry_chk #(
  parameter int unsigned EXC_W = 6
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        busy_o,
  input logic        instr_done_i,
  input logic        mem_we_o,
  input logic        mem_ack_i,
  input logic [31:0] mem_addr_o,
  input logic [31:0] mem_wdata_o,
  input logic        vec_req_o,
  input logic        vec_ack_i,
  input logic [31:0] vec_addr_o,
  input logic [31:0] vec_base_i,
  input logic [31:0] vec_data_i,
  input logic        done_o,
  input logic [31:0] sp_o,
  input logic [31:0] lr_o,
  input logic [31:0] psr_o,
  input logic [31:0] pc_o
);
  logic        retired_q;
  logic [3:0]  wr_cnt_q;
  logic [31:0] sp0_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      retired_q <= 1'b0;
      wr_cnt_q  <= '0;
      sp0_q     <= '0;
    end else if (!busy_o) begin
      retired_q <= 1'b0;
      wr_cnt_q  <= '0;
    end else begin
      if (instr_done_i) retired_q <= 1'b1;
      if (mem_we_o && wr_cnt_q == 4'd0) sp0_q <= mem_addr_o + 32'd4;
      if (mem_we_o && mem_ack_i) wr_cnt_q <= wr_cnt_q + 4'd1;
    end
  end

  AST_WRITE_AFTER_RETIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> retired_q); // R1
  AST_EIGHT_WORDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> wr_cnt_q == 4'd8); // R2
  AST_SP_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_ack_i) |=> (!mem_we_o || mem_addr_o == $past(mem_addr_o) - 32'd4)); // R3
  AST_FINAL_SP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> sp_o == sp0_q - 32'd32); // R4
  AST_RET_MARKER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> lr_o == 32'hFFFF_FFF9); // R5
  AST_VEC_AFTER_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> (wr_cnt_q == 4'd8 && !mem_we_o)); // R7
  AST_VEC_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_req_o |-> vec_addr_o == vec_base_i + {{(30-EXC_W){1'b0}}, psr_o[EXC_W-1:0], 2'b00}); // R7
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vec_req_o && vec_ack_i) |=> (done_o && pc_o == $past(vec_data_i))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R8
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !mem_ack_i) |=> (mem_we_o && $stable(mem_addr_o) && $stable(mem_wdata_o))); // R10
endmodule

bind exc_entry_seq exc_entry_chk #(.EXC_W(EXC_W)) u_chk (.*);

// File: tb/tb_exc_entry_seq.sv
`timescale 1ns/1ps
module tb_exc_entry_seq;
  localparam int unsigned EXC_W = 6;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic take_i = 0, instr_done_i = 0, mem_ack_i = 0, vec_ack_i = 0;
  logic [EXC_W-1:0] exc_num_i = '0;
  logic [31:0] psr_i = 0, pc_i = 0, lr_i = 0, r12_i = 0, r3_i = 0, r2_i = 0, r1_i = 0, r0_i = 0;
  logic [31:0] sp_i = 0, vec_base_i = 0, vec_data_i = 0;
  logic        mem_we_o, vec_req_o, busy_o, done_o;
  logic [31:0] mem_addr_o, mem_wdata_o, vec_addr_o, sp_o, lr_o, psr_o, pc_o;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  exc_entry_seq #(.EXC_W(EXC_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic run_entry(input int n, input int bdly, input int lat, input bit poke_take, input bit poke_regs);
    logic [31:0] exp_w [8];
    logic [31:0] sp0, base, hnd;
    int wcnt = 0, lcnt = 0, cyc = 0;
    bit early = 0, got_done = 0, vec_ok = 1, extra = 0;
    sp0  = 32'h2000_8000 - 32'(n) * 32'd128;
    base = 32'h0010_0000 + 32'(n % 4) * 32'h400;
    hnd  = 32'h0800_0001 + 32'(n) * 32'd16;
    psr_i = 32'h8123_45FF ^ (32'(n) << 12);
    pc_i  = 32'h0000_2000 + 32'(n) * 8;
    lr_i  = 32'h0000_3001 + 32'(n);
    r12_i = {8'hC0, 16'(n), 8'h12};
    r3_i  = {8'hA3, 16'(n), 8'h03};
    r2_i  = {8'hA2, 16'(n), 8'h02};
    r1_i  = {8'hA1, 16'(n), 8'h01};
    r0_i  = {8'hA0, 16'(n), 8'h00};
    sp_i = sp0; vec_base_i = base;
    exp_w = '{psr_i, pc_i, lr_i, r12_i, r3_i, r2_i, r1_i, r0_i};
    take_i = 1; exc_num_i = EXC_W'(n);
    @(negedge clk_i);
    take_i = 0;
    for (int i = 0; i < bdly; i++) begin
      if (mem_we_o) early = 1;
      @(negedge clk_i);
    end
    if (mem_we_o) early = 1;
    chk(!early, "R1 write before boundary", 32'(early), 0);
    instr_done_i = 1;
    @(negedge clk_i);
    instr_done_i = 0;
    while (!got_done && cyc < 300) begin
      mem_ack_i = 0; vec_ack_i = 0; take_i = 0;
      if (poke_regs && wcnt == 2) begin
        psr_i = ~psr_i; pc_i = ~pc_i; lr_i = ~lr_i; r12_i = ~r12_i;
        r3_i = ~r3_i; r2_i = ~r2_i; r1_i = ~r1_i; r0_i = ~r0_i;
      end
      if (poke_take && wcnt == 3) begin
        take_i = 1; exc_num_i = EXC_W'(n + 1);
      end
      if (done_o) begin
        got_done = 1;
        chk(sp_o == sp0 - 32, "R4 final sp", sp_o, sp0 - 32);
        chk(lr_o == 32'hFFFF_FFF9, "R5 lr marker", lr_o, 32'hFFFF_FFF9);
        chk(psr_o == {exp_w[0][31:EXC_W], 6'(n)}, "R6 psr field", psr_o, {exp_w[0][31:EXC_W], 6'(n)});
        chk(pc_o == hnd, "R7 pc handler", pc_o, hnd);
        chk(wcnt == 8, "R2 word count", 32'(wcnt), 8);
      end else if (mem_we_o) begin
        if (wcnt >= 8) extra = 1;
        else if (lcnt == lat) begin
          chk(mem_addr_o == sp0 - 32'(4 * (wcnt + 1)), "R3 push addr", mem_addr_o, sp0 - 32'(4 * (wcnt + 1)));
          chk(mem_wdata_o == exp_w[wcnt], poke_regs ? "R11 snapshot word" : "R2 push word", mem_wdata_o, exp_w[wcnt]);
          mem_ack_i = 1; wcnt++; lcnt = 0;
        end else lcnt++;
      end else if (vec_req_o) begin
        if (wcnt != 8) vec_ok = 0;
        if (lcnt == lat) begin
          chk(vec_addr_o == base + 32'(4 * n), "R7 vector addr", vec_addr_o, base + 32'(4 * n));
          vec_data_i = hnd; vec_ack_i = 1; lcnt = 0;
        end else lcnt++;
      end else if (lcnt > 0 && lat > 0 && wcnt > 0 && wcnt < 8) begin
        chk(0, "R10 request dropped", 32'(wcnt), 8);
      end
      @(negedge clk_i);
      cyc++;
    end
    mem_ack_i = 0; vec_ack_i = 0; take_i = 0;
    chk(got_done, "R8 done seen", 32'(got_done), 1);
    chk(vec_ok && !extra, "R7 vector after eight writes", 32'(wcnt), 8);
    chk(!done_o && !busy_o, "R8 done one cycle", {30'd0, done_o, busy_o}, 0);
    if (poke_take) begin
      bit rearmed = 0;
      for (int i = 0; i < 4; i++) begin
        if (busy_o || mem_we_o) rearmed = 1;
        @(negedge clk_i);
      end
      chk(!rearmed, "R9 take ignored while busy", 32'(rearmed), 0);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !mem_we_o && !vec_req_o && !done_o, "R8 reset idle",
        {28'd0, busy_o, mem_we_o, vec_req_o, done_o}, 0);
    rst_ni = 1;
    @(negedge clk_i);
    for (int n = 0; n < 64; n++)
      run_entry(n, n % 4, n % 3, (n % 5) == 1, (n % 7) == 2);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule